// File: doc/BRIEF.md
# Dual-Issue Pairing Checker with Load-Operand Bonding

The block sits between instruction decode and two execution pipes. Each cycle it looks at two adjacent decoded instructions, an older slot A and a younger slot B. It decides whether both may issue in the same cycle, only A may issue, or nothing issues. Slot B can depend on slot A through a register. Normally that dependency keeps B back. There is one exception: A loads a data register from memory through an address register, and B is a single-cycle ALU operation that reads that data register. In that case B is rewritten to take the same memory operand directly, and the pair still issues together. A keeps writing its own register as usual.

Each slot record may itself hold an already fused pair. The checker treats such a record as one issue slot, like any other. The decision and the possibly rewritten copy of B are registered, so they appear one clock after the records are presented. Registers are numbered with a 4-bit index (by default). The most significant bit is 0 for data registers and 1 for address registers.

Top module: `pair_issue_check`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output is zero after that edge.
- R2: Outputs are registered with exactly one cycle of latency. The decision for the inputs sampled at edge k is visible after edge k and stays until the next edge.
- R3: With both slots valid and no dependency, `issue_both` is 1 and `issue_one` is 0. A dependency is a source of B equal to A's destination while A writes a register. A shared destination with both writing is a second kind of dependency. `issue_both` and `issue_one` are never 1 together.
- R4: When A writes a register that an enabled source of B reads, and bonding does not apply, only A issues (`issue_one`=1, `issue_both`=0).
- R5: When A and B both write the same destination register, only A issues, even if bonding would otherwise apply.
- R6: Bonding applies when all of these hold: A has `a_load`=1, A's destination is a data register (index MSB 0), B's class is ALU (`b_cls`=2'b00), and B reads A's destination. Then `issue_both`=1 and `bonded`=1. Bit i of `rb_src_mem` is 1 for each enabled source i of B that matches. `rb_mem_areg` equals `a_areg`.
- R7: If B writes the address register A loads through (`b_wr`=1 and `b_dst`=`a_areg`), bonding is refused and only A issues.
- R8: If A is invalid, nothing issues. If A is valid and B is invalid, only A issues.
- R9: `rb_cls`, `rb_wr`, `rb_dst`, `rb_src` and `rb_src_en` are B's fields, registered and unchanged. When not bonded, `bonded`, `rb_src_mem` and `rb_mem_areg` are zero.
- R10: A dependency on a load whose destination is an address register is not bonded, and only A issues. The same holds for a consumer whose class is not ALU (01 memory, 10 branch, 11 long-latency).
- R11: A source of B whose enable bit is 0 never creates a dependency, whatever its index.
- R12: When `a_wr` is 0, A creates neither a read-after-write nor a write-after-write conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_valid | input | 1 | Slot A holds an instruction |
| a_wr | input | 1 | Slot A writes a register |
| a_dst | input | REG_W | Slot A destination register index |
| a_load | input | 1 | Slot A loads its destination from memory |
| a_areg | input | REG_W | Address register of slot A's load |
| b_valid | input | 1 | Slot B holds an instruction |
| b_cls | input | 2 | Slot B class: 00 ALU, 01 memory, 10 branch, 11 long-latency |
| b_wr | input | 1 | Slot B writes a register |
| b_dst | input | REG_W | Slot B destination register index |
| b_src | input | NSRC*REG_W | Slot B source indices, source i at bits i*REG_W upward |
| b_src_en | input | NSRC | Slot B source enables |
| issue_both | output | 1 | Both slots issue this cycle |
| issue_one | output | 1 | Only slot A issues |
| bonded | output | 1 | Slot B was rewritten by bonding |
| rb_cls | output | 2 | Issued B class |
| rb_wr | output | 1 | Issued B write enable |
| rb_dst | output | REG_W | Issued B destination |
| rb_src | output | NSRC*REG_W | Issued B source indices |
| rb_src_en | output | NSRC | Issued B source enables |
| rb_src_mem | output | NSRC | Per source: operand redirected to memory |
| rb_mem_areg | output | REG_W | Address register of the redirected memory operand |

## Verification
Some rules are checked by assertions on every cycle. These are: the reset state, the exclusivity of the two issue flags, silence when A is invalid, the block on a shared destination, the block on a plain register dependency through source 0, and the refusal of bonding when B overwrites the load's address register. A bonded output must also come with dual issue and a redirected source. Other cases can only be shown by the bench scenarios, where a behavioural model predicts every output. These cases are: which source bits get redirected when both sources match, pass-through of B's fields, disabled sources and non-writing A slots, and the exclusions by class and by address-register destination.

// File: rtl/pair_pkg.sv
// Shared types for the pairing checker.
// Assumes the decoder encodes the instruction class in two bits.
package pair_pkg;

    typedef enum logic [1:0] {
        CLS_ALU  = 2'b00,
        CLS_MEM  = 2'b01,
        CLS_BR   = 2'b10,
        CLS_LONG = 2'b11
    } op_cls_e;

    typedef struct packed {
        logic both;
        logic one;
        logic bond;
    } issue_t;

endpackage

// File: rtl/pair_hazard.sv
// Finds register conflicts between slot A (older) and slot B (younger).
// Assumes source enables qualify every source index of B.
module pair_hazard #(
    parameter int REG_W = 4,
    parameter int NSRC  = 2
) (
    input  logic                  a_wr,
    input  logic [REG_W-1:0]      a_dst,
    input  logic                  b_wr,
    input  logic [REG_W-1:0]      b_dst,
    input  logic [NSRC*REG_W-1:0] b_src,
    input  logic [NSRC-1:0]       b_src_en,
    output logic [NSRC-1:0]       src_hit,
    output logic                  raw,
    output logic                  waw
);

    // One comparator per source of B against A's destination.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign src_hit[i] = a_wr && b_src_en[i] &&
                            (b_src[i*REG_W +: REG_W] == a_dst);
    end

    // Reduce the per-source hits and check for a shared destination.
    always_comb begin
        raw = |src_hit;
        waw = a_wr && b_wr && (a_dst == b_dst);
    end

endmodule

// File: rtl/pair_bond.sv
// Judges whether a load in slot A can hand its memory operand to slot B.
// Assumes register index MSB 0 marks a data register.
module pair_bond #(
    parameter int REG_W = 4
) (
    input  logic             a_load,
    input  logic [REG_W-1:0] a_dst,
    input  logic [REG_W-1:0] a_areg,
    input  logic [1:0]       b_cls,
    input  logic             b_wr,
    input  logic [REG_W-1:0] b_dst,
    output logic             bond_ok
);
    import pair_pkg::*;

    localparam int KIND_BIT = REG_W - 1;

    // Bondable: data-register load feeding an ALU op that keeps the address register intact.
    always_comb begin
        bond_ok = a_load && !a_dst[KIND_BIT] && (b_cls == CLS_ALU) &&
                  !(b_wr && (b_dst == a_areg));
    end

endmodule

// File: rtl/pair_decide.sv
// Combines slot validity, conflicts and bondability into one issue decision.
// Assumes raw/waw are already qualified by A's write enable.
module pair_decide (
    input  logic            a_valid,
    input  logic            b_valid,
    input  logic            raw,
    input  logic            waw,
    input  logic            bond_ok,
    output pair_pkg::issue_t dec
);

    // Priority: invalid A, invalid B, shared destination, dependency, free pair.
    always_comb begin
        dec = '0;
        if (!a_valid) begin
            dec = '0;
        end else if (!b_valid || waw) begin
            dec.one = 1'b1;
        end else if (raw) begin
            dec.both = bond_ok;
            dec.one  = !bond_ok;
            dec.bond = bond_ok;
        end else begin
            dec.both = 1'b1;
        end
    end

endmodule

// File: rtl/pair_out_reg.sv
// Output stage: registers the decision and the rewritten copy of slot B.
// Assumes a synchronous active-low reset clears every output.
module pair_out_reg #(
    parameter int REG_W = 4,
    parameter int NSRC  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  pair_pkg::issue_t      dec,
    input  logic [NSRC-1:0]       src_hit,
    input  logic [REG_W-1:0]      a_areg,
    input  logic [1:0]            b_cls,
    input  logic                  b_wr,
    input  logic [REG_W-1:0]      b_dst,
    input  logic [NSRC*REG_W-1:0] b_src,
    input  logic [NSRC-1:0]       b_src_en,
    output logic                  issue_both,
    output logic                  issue_one,
    output logic                  bonded,
    output logic [1:0]            rb_cls,
    output logic                  rb_wr,
    output logic [REG_W-1:0]      rb_dst,
    output logic [NSRC*REG_W-1:0] rb_src,
    output logic [NSRC-1:0]       rb_src_en,
    output logic [NSRC-1:0]       rb_src_mem,
    output logic [REG_W-1:0]      rb_mem_areg
);

    // Capture the decision and B, redirecting matched sources when bonded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_both  <= 1'b0;
            issue_one   <= 1'b0;
            bonded      <= 1'b0;
            rb_cls      <= '0;
            rb_wr       <= 1'b0;
            rb_dst      <= '0;
            rb_src      <= '0;
            rb_src_en   <= '0;
            rb_src_mem  <= '0;
            rb_mem_areg <= '0;
        end else begin
            issue_both  <= dec.both;
            issue_one   <= dec.one;
            bonded      <= dec.bond;
            rb_cls      <= b_cls;
            rb_wr       <= b_wr;
            rb_dst      <= b_dst;
            rb_src      <= b_src;
            rb_src_en   <= b_src_en;
            rb_src_mem  <= dec.bond ? src_hit : '0;
            rb_mem_areg <= dec.bond ? a_areg : '0;
        end
    end

    // R3: the two issue flags never rise together.
    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({issue_both, issue_one}));

    // R6: a bonded B always dual-issues with at least one redirected source.
    a_r6_bond_shape: assert property (@(posedge clk) disable iff (!rst_n)
        bonded |-> (issue_both && (rb_src_mem != '0)));

endmodule

// File: rtl/pair_issue_check.sv
// Top of the dual-issue pairing checker with load-operand bonding.
// Assumes decoded records arrive from an earlier decode stage each cycle.
module pair_issue_check #(
    parameter int REG_W = 4,
    parameter int NSRC  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  a_valid,
    input  logic                  a_wr,
    input  logic [REG_W-1:0]      a_dst,
    input  logic                  a_load,
    input  logic [REG_W-1:0]      a_areg,
    input  logic                  b_valid,
    input  logic [1:0]            b_cls,
    input  logic                  b_wr,
    input  logic [REG_W-1:0]      b_dst,
    input  logic [NSRC*REG_W-1:0] b_src,
    input  logic [NSRC-1:0]       b_src_en,
    output logic                  issue_both,
    output logic                  issue_one,
    output logic                  bonded,
    output logic [1:0]            rb_cls,
    output logic                  rb_wr,
    output logic [REG_W-1:0]      rb_dst,
    output logic [NSRC*REG_W-1:0] rb_src,
    output logic [NSRC-1:0]       rb_src_en,
    output logic [NSRC-1:0]       rb_src_mem,
    output logic [REG_W-1:0]      rb_mem_areg
);

    logic [NSRC-1:0]  src_hit;
    logic             raw;
    logic             waw;
    logic             bond_ok;
    pair_pkg::issue_t dec;

    pair_hazard #(.REG_W(REG_W), .NSRC(NSRC)) u_hazard (
        .a_wr     (a_wr),
        .a_dst    (a_dst),
        .b_wr     (b_wr),
        .b_dst    (b_dst),
        .b_src    (b_src),
        .b_src_en (b_src_en),
        .src_hit  (src_hit),
        .raw      (raw),
        .waw      (waw)
    );

    pair_bond #(.REG_W(REG_W)) u_bond (
        .a_load  (a_load),
        .a_dst   (a_dst),
        .a_areg  (a_areg),
        .b_cls   (b_cls),
        .b_wr    (b_wr),
        .b_dst   (b_dst),
        .bond_ok (bond_ok)
    );

    pair_decide u_decide (
        .a_valid (a_valid),
        .b_valid (b_valid),
        .raw     (raw),
        .waw     (waw),
        .bond_ok (bond_ok),
        .dec     (dec)
    );

    pair_out_reg #(.REG_W(REG_W), .NSRC(NSRC)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .dec         (dec),
        .src_hit     (src_hit),
        .a_areg      (a_areg),
        .b_cls       (b_cls),
        .b_wr        (b_wr),
        .b_dst       (b_dst),
        .b_src       (b_src),
        .b_src_en    (b_src_en),
        .issue_both  (issue_both),
        .issue_one   (issue_one),
        .bonded      (bonded),
        .rb_cls      (rb_cls),
        .rb_wr       (rb_wr),
        .rb_dst      (rb_dst),
        .rb_src      (rb_src),
        .rb_src_en   (rb_src_en),
        .rb_src_mem  (rb_src_mem),
        .rb_mem_areg (rb_mem_areg)
    );

    // R1: a reset edge leaves all decision outputs cleared.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!issue_both && !issue_one && !bonded && (rb_src_mem == '0)));

    // R8: an empty slot A issues nothing.
    a_r8_no_a_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
        !a_valid |=> (!issue_both && !issue_one));

    // R5: a shared destination blocks dual issue.
    a_r5_shared_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && b_valid && a_wr && b_wr && (a_dst == b_dst)) |=> !issue_both);

    // R4: a non-load producer feeding source 0 of B blocks dual issue.
    a_r4_plain_dep: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && b_valid && a_wr && !a_load && b_src_en[0] &&
         (b_src[REG_W-1:0] == a_dst)) |=> !issue_both);

    // R7: B overwriting the load's address register prevents bonding.
    a_r7_areg_clobber: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && b_valid && a_load && b_wr && (b_dst == a_areg)) |=> !bonded);

endmodule

// File: tb/sim_pair_issue_check.sv
// Bench: behavioural reference model compared against the design every cycle.
module sim_pair_issue_check;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a_valid = 0, a_wr = 0, a_load = 0;
    logic [3:0] a_dst = 0, a_areg = 0;
    logic       b_valid = 0, b_wr = 0;
    logic [1:0] b_cls = 0;
    logic [3:0] b_dst = 0;
    logic [7:0] b_src = 0;
    logic [1:0] b_src_en = 0;
    logic       issue_both, issue_one, bonded, rb_wr;
    logic [1:0] rb_cls, rb_src_en, rb_src_mem;
    logic [3:0] rb_dst, rb_mem_areg;
    logic [7:0] rb_src;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #2.5 clk = ~clk;

    pair_issue_check u0 (
        .clk(clk), .rst_n(rst_n),
        .a_valid(a_valid), .a_wr(a_wr), .a_dst(a_dst), .a_load(a_load), .a_areg(a_areg),
        .b_valid(b_valid), .b_cls(b_cls), .b_wr(b_wr), .b_dst(b_dst),
        .b_src(b_src), .b_src_en(b_src_en),
        .issue_both(issue_both), .issue_one(issue_one), .bonded(bonded),
        .rb_cls(rb_cls), .rb_wr(rb_wr), .rb_dst(rb_dst), .rb_src(rb_src),
        .rb_src_en(rb_src_en), .rb_src_mem(rb_src_mem), .rb_mem_areg(rb_mem_areg)
    );

    function automatic bit cmp(string req, string what, int act, int exp);
        if (act != exp) begin
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
            return 1'b0;
        end
        return 1'b1;
    endfunction

    // Drive one vector at a falling edge, predict, and compare at the next falling edge.
    task automatic apply(input bit rs, input bit av, input bit aw, input int ad, input bit al,
                         input int aa, input bit bv, input int bc, input bit bw, input int bd,
                         input int s0, input int s1, input int en, input string note);
        int    hit[2];
        int    mem, both, one, bnd, areg_o;
        bit    dep, shared, canbond, ok;
        string req;
        rst_n = rs; a_valid = av; a_wr = aw; a_dst = 4'(ad); a_load = al; a_areg = 4'(aa);
        b_valid = bv; b_cls = 2'(bc); b_wr = bw; b_dst = 4'(bd);
        b_src = {4'(s1), 4'(s0)}; b_src_en = 2'(en);
        hit[0] = (aw && en[0] && s0 == ad) ? 1 : 0;
        hit[1] = (aw && en[1] && s1 == ad) ? 1 : 0;
        dep     = (hit[0] + hit[1]) > 0;
        shared  = aw && bw && (ad == bd);
        canbond = al && (ad < 8) && (bc == 0) && !(bw && bd == aa);
        both = 0; one = 0; bnd = 0; mem = 0; areg_o = 0;
        if (!rs)               req = "R1";
        else if (!av)          begin req = "R8"; end
        else if (!bv)          begin req = "R8"; one = 1; end
        else if (shared)       begin req = "R5"; one = 1; end
        else if (dep && canbond) begin
            req = "R6"; both = 1; bnd = 1; mem = hit[0] + 2 * hit[1]; areg_o = aa;
        end
        else if (dep)          begin req = (al && bw && bd == aa) ? "R7" : (al ? "R10" : "R4"); one = 1; end
        else                   begin req = "R3"; both = 1; end
        req = {req, " ", note};
        @(negedge clk);
        n_vec++;
        ok = 1;
        ok &= cmp(req, "issue_both", int'(issue_both), both);
        ok &= cmp(req, "issue_one", int'(issue_one), one);
        ok &= cmp(req, "bonded", int'(bonded), bnd);
        ok &= cmp(req, "rb_src_mem", int'(rb_src_mem), mem);
        ok &= cmp(req, "rb_mem_areg", int'(rb_mem_areg), areg_o);
        ok &= cmp(req, "rb_cls", int'(rb_cls), rs ? bc : 0);
        ok &= cmp(req, "rb_wr", int'(rb_wr), rs ? int'(bw) : 0);
        ok &= cmp(req, "rb_dst", int'(rb_dst), rs ? bd : 0);
        ok &= cmp(req, "rb_src", int'(rb_src), rs ? (s1 * 16 + s0) : 0);
        ok &= cmp(req, "rb_src_en", int'(rb_src_en), rs ? en : 0);
        if (!ok) n_bad++;
    endtask

    initial begin
        @(negedge clk);
        // R1: reset holds outputs clear even with a valid pair presented.
        apply(0, 1, 1, 1, 0, 8, 1, 0, 1, 4, 2, 3, 3, "R1 reset");
        apply(0, 1, 1, 1, 0, 8, 1, 0, 1, 4, 2, 3, 3, "R1 reset");
        // R3 / R2: independent pairs back to back, each visible one cycle later.
        apply(1, 1, 1, 1, 0, 8, 1, 0, 1, 4, 2, 3, 3, "R3 free pair");
        apply(1, 1, 1, 5, 0, 8, 1, 0, 1, 4, 5, 3, 2, "R2 next vector latency");
        // R4: plain register dependency.
        apply(1, 1, 1, 1, 0, 8, 1, 0, 1, 4, 1, 3, 3, "R4 plain dep");
        // R5: shared destination, even with bondable load.
        apply(1, 1, 1, 3, 1, 9, 1, 0, 1, 3, 3, 5, 3, "R5 shared dst");
        // R6: bonding on source 0, then on both sources.
        apply(1, 1, 1, 2, 1, 9, 1, 0, 1, 5, 2, 6, 3, "R6 bond src0");
        apply(1, 1, 1, 2, 1, 12, 1, 0, 1, 6, 2, 2, 3, "R6 bond both srcs");
        apply(1, 1, 1, 4, 1, 10, 1, 0, 0, 0, 7, 4, 2, "R6 bond src1 no write");
        // R7: B writes A's address register.
        apply(1, 1, 1, 2, 1, 9, 1, 0, 1, 9, 2, 6, 3, "R7 areg clobber");
        // R10: non-ALU consumer and address-register load destination.
        apply(1, 1, 1, 2, 1, 9, 1, 1, 1, 5, 2, 6, 3, "R10 memory class");
        apply(1, 1, 1, 2, 1, 9, 1, 3, 1, 5, 2, 6, 3, "R10 long class");
        apply(1, 1, 1, 10, 1, 9, 1, 0, 1, 5, 10, 6, 3, "R10 areg dst");
        // R11: disabled source ignored.
        apply(1, 1, 1, 2, 0, 9, 1, 0, 1, 5, 2, 2, 0, "R11 disabled srcs");
        // R12: A not writing.
        apply(1, 1, 0, 5, 0, 9, 1, 0, 1, 5, 5, 5, 3, "R12 no write");
        // R8: invalid slots.
        apply(1, 0, 1, 1, 0, 8, 1, 0, 1, 4, 2, 3, 3, "R8 A invalid");
        apply(1, 1, 1, 1, 0, 8, 0, 0, 1, 4, 2, 3, 3, "R8 B invalid");
        // R9: pass-through of B fields on a non-bonded vector.
        apply(1, 1, 1, 7, 0, 8, 1, 2, 0, 11, 13, 14, 1, "R9 passthrough");
        // Mixed traffic on a small register set to provoke collisions.
        for (int i = 0; i < 3000; i++) begin
            apply(($urandom % 50) != 0, ($urandom % 8) != 0, $urandom % 2,
                  int'($urandom % 4) + (($urandom % 5 == 0) ? 8 : 0), $urandom % 2,
                  8 + int'($urandom % 2), ($urandom % 8) != 0, int'($urandom % 4),
                  $urandom % 2, int'($urandom % 4) + 8 * int'($urandom % 2),
                  int'($urandom % 4), int'($urandom % 4), int'($urandom % 4), "R9 mixed");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule